// File: doc/BRIEF.md
# Cartridge Bank Mapper with Rotated Protection Port

This block sits between a CPU-side cartridge bus and two ROM arrays. It holds a small protection register set (a 4-bit accumulator, a 4-bit staging value, a 4-bit high nibble, an invert flag and a count-mode flag). The CPU loads these registers with writes into a low I/O window. A read from that window returns a value computed from the registers. A write anywhere in the upper half of the address space freezes the current register value into an output byte, and the ROM bank numbers are taken from that byte.

Bus data passes through a two-bit rotation in both directions. Write data is rotated right before it reaches the registers, and read data is rotated left before it reaches the CPU. The PRG bank is built from two output bits that are not next to each other. The CHR bank is a 4-bit field of the output byte. The block produces a PRG ROM address for one 32 KiB window and a CHR ROM address for one 8 KiB window. The ROM arrays themselves are outside this block.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write is accepted only at 0x4020–0x5FFF (register window) or 0x8000–0xFFFF (capture window). A write at 0x6000–0x7FFF or below 0x4020 changes no register, no read value and no bank.
- R2: Write data d reaches the registers as {d[1:0], d[7:2]}, which is d rotated right by two bits.
- R3: A read with cpu_rd high, address in 0x4020–0x5FFF, bit 8 = 1 and bits 1:0 = 00 returns the chip value r rotated left by two bits, {r[5:0], r[7:6]}, in the same cycle.
- R4: In the register window, a write decodes only when address bits 15:13 = 010 and bit 8 = 1. Bits 1:0 then select the register. 0 = latch accumulator. 1 = invert flag, taken from rotated bit 0. 2 = staging value from rotated bits 3:0 and high nibble from rotated bits 7:4. 3 = count mode, taken from rotated bit 0.
- R5: On a latch write, the accumulator becomes (accumulator + 1) mod 16 when count mode is set. When count mode is clear, it becomes staging XOR 0xF if invert is set, and staging unchanged if invert is clear.
- R6: The chip value is {high nibble XOR (invert ? 0xF : 0x0), accumulator}.
- R7: The output byte becomes {high nibble, accumulator} only on a write at 0x8000 or above. The banks follow that byte from the next clock edge and otherwise hold.
- R8: The PRG bank is {out[5], out[0]}. The PRG ROM address is {PRG bank, cpu_addr[14:0]}.
- R9: The CHR bank is out[4:1]. The CHR ROM address is {CHR bank, ppu_addr[12:0]}.
- R10: Synchronous reset sets invert to 1 and clears every other register and both banks. A qualifying read at 0x4100 then returns 0xC3.
- R11: A read that does not qualify under R3, or any cycle with cpu_rd low, returns open_bus on cpu_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| open_bus | input | 8 | Value returned when the block does not drive a read |
| ppu_addr | input | 14 | PPU pattern address |
| cpu_rdata | output | 8 | CPU read data |
| prg_rom_addr | output | 17 | Banked PRG ROM address |
| chr_rom_addr | output | 17 | Banked CHR ROM address |

## Verification
Register writes take effect at the first rising edge on which cpu_wr is high. Banks change at the edge that captures a write at 0x8000 or above, so they are visible one cycle after the strobe. Read data and the ROM offset bits are combinational and valid in the same cycle as the address. The bench drives inputs on the falling edge and samples 1 ns later. A write's result is therefore read back only after the rising edge that stored it, and a read is observed before the next rising edge. Checks taken between register setup and the capture write confirm that the banks have not moved early.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int NIB_W    = 4;
    localparam int ROT_AMT  = 2;

    localparam logic [CPU_AW-1:0] LOW_WIN_LO = 16'h4020;
    localparam logic [CPU_AW-1:0] LOW_WIN_HI = 16'h5FFF;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef enum logic [1:0] {
        SEL_LATCH  = 2'd0,
        SEL_INVERT = 2'd1,
        SEL_LOAD   = 2'd2,
        SEL_COUNT  = 2'd3
    } chip_sel_e;

    typedef struct packed {
        logic      reg_wr;
        logic      cap_wr;
        logic      rd_hit;
        chip_sel_e sel;
    } bus_dec_t;

    typedef struct packed {
        nib_t hi;
        nib_t acc;
    } chip_word_t;

    function automatic byte_t rot_right(input byte_t d);
        return {d[ROT_AMT-1:0], d[DATA_W-1:ROT_AMT]};
    endfunction

    function automatic byte_t rot_left(input byte_t d);
        return {d[DATA_W-ROT_AMT-1:0], d[DATA_W-1:DATA_W-ROT_AMT]};
    endfunction

endpackage

// File: rtl/cbm_bus_qual.sv
module cbm_bus_qual
    import cbm_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output bus_dec_t          dec
);
    logic in_low;
    logic upper;

    always_comb begin
        in_low = (cpu_addr >= LOW_WIN_LO) && (cpu_addr <= LOW_WIN_HI);
        upper  = cpu_addr[CPU_AW-1];
        dec.reg_wr = cpu_wr && in_low && (cpu_addr[15:13] == 3'b010) && cpu_addr[8];
        dec.cap_wr = cpu_wr && upper;
        dec.rd_hit = cpu_rd && in_low && cpu_addr[8] && (cpu_addr[1:0] == 2'b00);
        dec.sel    = chip_sel_e'(cpu_addr[1:0]);
    end
endmodule

// File: rtl/cbm_prot_chip.sv
module cbm_prot_chip
    import cbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_dec_t dec,
    input  byte_t    wval,
    output byte_t    chip_rd,
    output byte_t    chip_out
);
    nib_t       acc_q, hi_q, stage_q;
    logic       inv_q, cnt_q;
    chip_word_t out_q;
    nib_t       inv_mask;

    assign inv_mask = {NIB_W{inv_q}};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            hi_q    <= '0;
            stage_q <= '0;
            inv_q   <= 1'b1;
            cnt_q   <= 1'b0;
        end else if (dec.reg_wr) begin
            unique case (dec.sel)
                SEL_LATCH:  acc_q <= cnt_q ? nib_t'(acc_q + 1'b1) : (stage_q ^ inv_mask);
                SEL_INVERT: inv_q <= wval[0];
                SEL_LOAD: begin
                    stage_q <= wval[NIB_W-1:0];
                    hi_q    <= wval[DATA_W-1:NIB_W];
                end
                SEL_COUNT:  cnt_q <= wval[0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             out_q <= '0;
        else if (dec.cap_wr) out_q <= '{hi: hi_q, acc: acc_q};
    end

    chip_word_t rd_w;
    always_comb begin
        rd_w    = '{hi: hi_q ^ inv_mask, acc: acc_q};
        chip_rd = byte_t'(rd_w);
    end

    assign chip_out = byte_t'(out_q);
endmodule

// File: rtl/cbm_bank_gen.sv
module cbm_bank_gen
    import cbm_pkg::*;
#(
    parameter int PRG_OFS_W  = 15,
    parameter int CHR_OFS_W  = 13,
    parameter int PPU_AW     = 14,
    parameter int PRG_BANK_W = 2,
    parameter int CHR_BANK_W = 4,
    localparam int PRG_AW    = PRG_BANK_W + PRG_OFS_W,
    localparam int CHR_AW    = CHR_BANK_W + CHR_OFS_W
)(
    input  byte_t             chip_out,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [CHR_AW-1:0] chr_rom_addr
);
    logic [PRG_BANK_W-1:0] prg_bank;
    logic [CHR_BANK_W-1:0] chr_bank;

    always_comb begin
        prg_bank     = {chip_out[5], chip_out[0]};
        chr_bank     = chip_out[CHR_BANK_W:1];
        prg_rom_addr = {prg_bank, cpu_addr[PRG_OFS_W-1:0]};
        chr_rom_addr = {chr_bank, ppu_addr[CHR_OFS_W-1:0]};
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int PRG_OFS_W  = 15,
    parameter int CHR_OFS_W  = 13,
    parameter int PPU_AW     = 14,
    localparam int PRG_AW    = 2 + PRG_OFS_W,
    localparam int CHR_AW    = 4 + CHR_OFS_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        open_bus,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [7:0]        cpu_rdata,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [CHR_AW-1:0] chr_rom_addr
);
    bus_dec_t dec;
    byte_t    wval;
    byte_t    chip_rd;
    byte_t    chip_out;

    cbm_bus_qual u_qual (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cpu_rd   (cpu_rd),
        .dec      (dec)
    );

    assign wval = rot_right(cpu_wdata);

    cbm_prot_chip u_chip (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .wval     (wval),
        .chip_rd  (chip_rd),
        .chip_out (chip_out)
    );

    cbm_bank_gen #(
        .PRG_OFS_W (PRG_OFS_W),
        .CHR_OFS_W (CHR_OFS_W),
        .PPU_AW    (PPU_AW)
    ) u_bank (
        .chip_out     (chip_out),
        .cpu_addr     (cpu_addr),
        .ppu_addr     (ppu_addr),
        .prg_rom_addr (prg_rom_addr),
        .chr_rom_addr (chr_rom_addr)
    );

    assign cpu_rdata = dec.rd_hit ? rot_left(chip_rd) : open_bus;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic [7:0]  open_bus,
    input logic [7:0]  cpu_rdata,
    input logic [16:0] prg_rom_addr,
    input logic [16:0] chr_rom_addr,
    input logic [7:0]  chip_rd
);
    logic qual_rd;
    assign qual_rd = cpu_rd && cpu_addr >= 16'h4020 && cpu_addr <= 16'h5FFF
                     && cpu_addr[8] && cpu_addr[1:0] == 2'b00;

    AST_BANKS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr[15]) |=> ($stable(prg_rom_addr[16:15]) && $stable(chr_rom_addr[16:13]))); // R7

    AST_RESET_BANKS: assert property (@(posedge clk)
        rst |=> (prg_rom_addr[16:15] == 2'd0 && chr_rom_addr[16:13] == 4'd0)); // R10

    AST_OPEN_BUS: assert property (@(posedge clk) disable iff (rst)
        !qual_rd |-> cpu_rdata == open_bus); // R11

    AST_READ_ROT: assert property (@(posedge clk) disable iff (rst)
        qual_rd |-> cpu_rdata == {chip_rd[5:0], chip_rd[7:6]}); // R3

    AST_IGNORED_WR: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_addr[15] && cpu_addr >= 16'h6000) |=> $stable(chip_rd)); // R1
endmodule

bind cart_bank_mapper cbm_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .open_bus     (open_bus),
    .cpu_rdata    (cpu_rdata),
    .prg_rom_addr (prg_rom_addr),
    .chr_rom_addr (chr_rom_addr),
    .chip_rd      (chip_rd)
);

// File: tb/cart_bank_mapper_test.sv
`timescale 1ns/100ps
module cart_bank_mapper_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  open_bus = 8'h5A;
    logic [13:0] ppu_addr = 14'h0456;
    logic [7:0]  cpu_rdata;
    logic [16:0] prg_rom_addr;
    logic [16:0] chr_rom_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cart_bank_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .open_bus(open_bus), .ppu_addr(ppu_addr),
        .cpu_rdata(cpu_rdata), .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    task automatic rom_addrs(output logic [16:0] p, output logic [16:0] c);
        @(negedge clk);
        cpu_addr = 16'h8123; ppu_addr = 14'h0456;
        #1 p = prg_rom_addr; c = chr_rom_addr;
    endtask

    task automatic t_reset_state();
        logic [7:0] v; logic [16:0] p, c;
        do_reset();
        rom_addrs(p, c);
        check("R10 prg after reset", p, 17'h00123);
        check("R10 chr after reset", c, 17'h00456);
        bus_read(16'h4100, v);
        check("R10 read 4100 after reset", v, 8'hC3);
        bus_read(16'h5104, v);
        check("R3 alias read 5104", v, 8'hC3);
    endtask

    task automatic t_prg_switch();
        logic [7:0] v; logic [16:0] p, c;
        do_reset();
        bus_write(16'h4101, 8'h00);
        bus_write(16'h4102, 8'h04);
        bus_write(16'h4100, 8'h00);
        rom_addrs(p, c);
        check("R7 prg before capture", p, 17'h00123);
        bus_read(16'h4100, v);
        check("R2 R6 rotated load read", v, 8'h04);
        bus_write(16'h8000, 8'h00);
        rom_addrs(p, c);
        check("R8 prg bank 1", p, 17'h08123);
        check("R9 chr bank 0", c, 17'h00456);
    endtask

    task automatic t_chr_switch();
        logic [16:0] p, c;
        do_reset();
        bus_write(16'h4101, 8'h00);
        bus_write(16'h4102, 8'h10);
        bus_write(16'h4100, 8'h00);
        bus_write(16'h8000, 8'hFF);
        rom_addrs(p, c);
        check("R9 chr bank 2", c, 17'h04456);
        check("R8 prg bank 0", p, 17'h00123);
    endtask

    task automatic t_invert_high();
        logic [7:0] v; logic [16:0] p, c;
        do_reset();
        bus_write(16'h4102, 8'h80);
        bus_write(16'h4100, 8'h00);
        bus_read(16'h4100, v);
        check("R5 R6 inverted latch read", v, 8'h7F);
        bus_write(16'h7FFF, 8'h00);
        bus_write(16'h6101, 8'h00);
        rom_addrs(p, c);
        check("R1 banks after 6000-7FFF writes", p, 17'h00123);
        bus_read(16'h4100, v);
        check("R1 invert kept after 6101 write", v, 8'h7F);
        bus_write(16'hC000, 8'h00);
        rom_addrs(p, c);
        check("R8 prg bank 3", p, 17'h18123);
        check("R9 chr bank 7", c, 17'h0E456);
        do_reset();
        rom_addrs(p, c);
        check("R10 prg cleared by reset", p, 17'h00123);
        check("R10 chr cleared by reset", c, 17'h00456);
    endtask

    task automatic t_count_mode();
        logic [7:0] v;
        do_reset();
        bus_write(16'h4101, 8'h00);
        bus_write(16'h4103, 8'h04);
        for (int i = 0; i < 3; i++) bus_write(16'h4100, 8'h00);
        bus_read(16'h4100, v);
        check("R5 count to 3", v, 8'h0C);
        bus_write(16'h4102, 8'h3C);
        for (int i = 0; i < 13; i++) bus_write(16'h4100, 8'h00);
        bus_read(16'h4100, v);
        check("R5 count wraps to 0", v, 8'h00);
        bus_write(16'h4103, 8'h00);
        bus_write(16'h4100, 8'h00);
        bus_read(16'h4100, v);
        check("R4 count off loads staging", v, 8'h3C);
    endtask

    task automatic t_open_bus();
        logic [7:0] v;
        do_reset();
        open_bus = 8'h5A;
        bus_read(16'h4101, v);
        check("R11 unaligned read", v, 8'h5A);
        bus_read(16'h6100, v);
        check("R11 read above window", v, 8'h5A);
        bus_read(16'h8100, v);
        check("R11 read in ROM space", v, 8'h5A);
        bus_read(16'h4000, v);
        check("R11 read below window", v, 8'h5A);
        @(negedge clk);
        cpu_addr = 16'h4100; cpu_rd = 1'b0;
        #1 check("R11 strobe low", cpu_rdata, 8'h5A);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_prg_switch();
        t_chr_switch();
        t_invert_high();
        t_count_mode();
        t_open_bus();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule